// File: doc/BRIEF.md
# Multiprocessor Interrupt Delivery Selector

This block decides, for every processor destination in a multiprocessor system, which pending interrupt source that processor should receive, and whether that processor's interrupt line should be raised at all. Each source carries a vector, a priority, a mask bit, a set of destinations given as a bitmask, a pending flag and an in-service flag kept separately for each destination. Each destination carries a task priority that acts as a delivery threshold. Selection is combinational over the live state, so any change to pending flags, priorities, masks, routing or task priorities is reflected on the interrupt lines one clock later.

A processor takes an interrupt by pulsing its acknowledge input. The block then returns the winner's vector, clears the winner's pending flag, marks the winner in service for that processor and lowers that processor's line. If nothing is deliverable, acknowledge returns the spurious vector and changes nothing. An end-of-interrupt pulse retires the highest-priority source in service for that processor, and selection continues from the new state. A source in service blocks new interrupts at equal or lower priority on that processor until it is retired.

Source settings, task priorities and pending requests enter through simple write strobes. Register decoding, timers, inter-processor messages and input edge or level conditioning sit outside this block.

Top module: `irq_dlv_sel`

## Requirements
- R1: A source competes for destination d only while it is pending, unmasked, and bit d of its destination mask is set; a source routed elsewhere never raises irq[d].
- R2: Among the sources competing for a destination, the highest priority wins; among equal priorities, the lowest source index wins.
- R3: irq[d] is high one cycle after the state makes the winner deliverable, where deliverable means its priority is strictly above the task priority of d and strictly above every priority currently in service for d; otherwise irq[d] is low one cycle later.
- R4: A task priority write stores the written value modulo 16 (its low 4 bits).
- R5: A source priority write stores the written value modulo 16 (its low 4 bits).
- R6: A masked source is never delivered and never returned by acknowledge; unmasking it later lets its kept pending request through.
- R7: A source of priority 0 never delivers, whatever the task priority.
- R8: An acknowledge on d while d has a deliverable winner puts the winner's vector on ack_vec[d] in the next cycle, clears its pending flag, marks it in service for d, and holds irq[d] low in that cycle.
- R9: An acknowledge on d with nothing deliverable puts spur_vec on ack_vec[d] in the next cycle and changes no source state.
- R10: An end-of-interrupt on d clears the in-service mark of the highest-priority source in service for d (lowest index on a tie); the next cycle's selection uses the new state.
- R11: When several destinations acknowledge in one cycle and share the same winner, the lowest-numbered destination receives it and the others receive spur_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_raise | input | N_SRC | One pulse per source sets its pending flag |
| cfg_we | input | 1 | Source settings write strobe |
| cfg_sel | input | clog2(N_SRC) | Source index written |
| cfg_prio | input | CFG_W | Priority written, reduced modulo 2**PRIO_W |
| cfg_vec | input | VEC_W | Vector written |
| cfg_mask | input | 1 | Mask bit written (1 = masked) |
| cfg_dst | input | N_DST | Destination bitmask written |
| tp_we | input | 1 | Task priority write strobe |
| tp_sel | input | clog2(N_DST) | Destination whose task priority is written |
| tp_val | input | CFG_W | Task priority written, reduced modulo 2**PRIO_W |
| spur_vec | input | VEC_W | Vector returned when nothing is deliverable |
| ack | input | N_DST | Acknowledge pulse per destination |
| eoi | input | N_DST | End-of-interrupt pulse per destination |
| irq | output | N_DST | Interrupt line per destination |
| ack_vec | output | N_DST x VEC_W | Vector returned by the last acknowledge per destination |

## Verification
The two functions that can meet in one cycle are the acknowledges of two processors that both see the same winning source, since one source can be routed to several destinations. The bench routes one source to both destinations, raises it, waits until both lines are high and then pulses both acknowledge inputs in the same cycle. It judges the outcome by requiring the vector on destination 0, the spurious vector on destination 1, and both lines low afterwards, which shows the source was claimed once and left pending for no one.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;

   // Width of an index able to address n items; never below one bit.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
   import irq_dlv_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned N_DST  = 2,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned CFG_W  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_SRC-1:0]                 raise,
   input  logic                             cfg_we,
   input  logic [idx_bits(N_SRC)-1:0]       cfg_sel,
   input  logic [CFG_W-1:0]                 cfg_prio,
   input  logic [VEC_W-1:0]                 cfg_vec,
   input  logic                             cfg_mask,
   input  logic [N_DST-1:0]                 cfg_dst,
   input  logic [N_SRC-1:0]                 pend_clr,
   input  logic [N_SRC-1:0][N_DST-1:0]      isv_set,
   input  logic [N_SRC-1:0][N_DST-1:0]      isv_clr,
   output logic [N_SRC-1:0][PRIO_W-1:0]     prio,
   output logic [N_SRC-1:0][VEC_W-1:0]      vec,
   output logic [N_SRC-1:0]                 mask,
   output logic [N_SRC-1:0][N_DST-1:0]      route,
   output logic [N_SRC-1:0]                 pend,
   output logic [N_SRC-1:0][N_DST-1:0]      isv
);

   localparam int unsigned SW     = idx_bits(N_SRC);
   localparam int unsigned LEVELS = 1 << PRIO_W;

   logic [PRIO_W-1:0] prio_mod;
   assign prio_mod = PRIO_W'(cfg_prio % CFG_W'(LEVELS));

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      logic hit;
      assign hit = cfg_we && (cfg_sel == SW'(s));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prio[s]  <= '0;
            vec[s]   <= '0;
            mask[s]  <= 1'b1;
            route[s] <= '0;
            pend[s]  <= 1'b0;
            isv[s]   <= '0;
         end else begin
            if (hit) begin
               prio[s]  <= prio_mod;
               vec[s]   <= cfg_vec;
               mask[s]  <= cfg_mask;
               route[s] <= cfg_dst;
            end
            // A new request in the same cycle as a claim keeps the source pending.
            pend[s] <= (pend[s] & ~pend_clr[s]) | raise[s];
            isv[s]  <= (isv[s] & ~isv_clr[s]) | isv_set[s];
         end
      end
   end

endmodule

// File: rtl/irq_dst_sel.sv
module irq_dst_sel
   import irq_dlv_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned PRIO_W = 4
) (
   input  logic [N_SRC-1:0][PRIO_W-1:0]     prio,
   input  logic [N_SRC-1:0]                 pend,
   input  logic [N_SRC-1:0]                 mask,
   input  logic [N_SRC-1:0]                 route,
   input  logic [N_SRC-1:0]                 isv,
   input  logic [PRIO_W-1:0]                tp,
   output logic [idx_bits(N_SRC)-1:0]       win_idx,
   output logic                             dlv,
   output logic                             eoi_vld,
   output logic [idx_bits(N_SRC)-1:0]       eoi_idx
);

   localparam int unsigned SW = idx_bits(N_SRC);

   logic              win_vld;
   logic [PRIO_W-1:0] win_prio;
   logic [PRIO_W-1:0] eoi_prio;

   // Strict comparison keeps the lowest index on equal priorities.
   always_comb begin
      win_vld  = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      eoi_vld  = 1'b0;
      eoi_idx  = '0;
      eoi_prio = '0;
      for (int s = 0; s < N_SRC; s++) begin
         if (pend[s] && !mask[s] && route[s] && (!win_vld || prio[s] > win_prio)) begin
            win_vld  = 1'b1;
            win_idx  = SW'(s);
            win_prio = prio[s];
         end
         if (isv[s] && (!eoi_vld || prio[s] > eoi_prio)) begin
            eoi_vld  = 1'b1;
            eoi_idx  = SW'(s);
            eoi_prio = prio[s];
         end
      end
      dlv = win_vld && (win_prio > tp) && (!eoi_vld || win_prio > eoi_prio);
   end

endmodule

// File: rtl/irq_dlv_sel.sv
module irq_dlv_sel
   import irq_dlv_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned N_DST  = 2,
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned VEC_W  = 8,
   parameter int unsigned CFG_W  = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [N_SRC-1:0]                 src_raise,
   input  logic                             cfg_we,
   input  logic [idx_bits(N_SRC)-1:0]       cfg_sel,
   input  logic [CFG_W-1:0]                 cfg_prio,
   input  logic [VEC_W-1:0]                 cfg_vec,
   input  logic                             cfg_mask,
   input  logic [N_DST-1:0]                 cfg_dst,
   input  logic                             tp_we,
   input  logic [idx_bits(N_DST)-1:0]       tp_sel,
   input  logic [CFG_W-1:0]                 tp_val,
   input  logic [VEC_W-1:0]                 spur_vec,
   input  logic [N_DST-1:0]                 ack,
   input  logic [N_DST-1:0]                 eoi,
   output logic [N_DST-1:0]                 irq,
   output logic [N_DST-1:0][VEC_W-1:0]      ack_vec
);

   localparam int unsigned SW     = idx_bits(N_SRC);
   localparam int unsigned DW     = idx_bits(N_DST);
   localparam int unsigned LEVELS = 1 << PRIO_W;

   if (N_SRC < 2) begin : g_bad_src
      $error("irq_dlv_sel: N_SRC must be at least 2");
   end
   if (N_DST < 1 || N_DST > 32) begin : g_bad_dst
      $error("irq_dlv_sel: N_DST must be in 1..32");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_dlv_sel: PRIO_W must be in 1..8");
   end
   if (CFG_W < PRIO_W) begin : g_bad_cfg
      $error("irq_dlv_sel: CFG_W must not be narrower than PRIO_W");
   end

   logic [N_SRC-1:0][PRIO_W-1:0] src_prio;
   logic [N_SRC-1:0][VEC_W-1:0]  src_vec;
   logic [N_SRC-1:0]             src_mask;
   logic [N_SRC-1:0][N_DST-1:0]  src_route;
   logic [N_SRC-1:0]             src_pend;
   logic [N_SRC-1:0][N_DST-1:0]  src_isv;

   logic [N_SRC-1:0]             claimed;
   logic [N_SRC-1:0][N_DST-1:0]  isv_set;
   logic [N_SRC-1:0][N_DST-1:0]  isv_clr;

   logic [N_DST-1:0][PRIO_W-1:0] tp_q;
   logic [N_DST-1:0][SW-1:0]     win_idx;
   logic [N_DST-1:0][SW-1:0]     eoi_idx;
   logic [N_DST-1:0]             eoi_vld;
   logic [N_DST-1:0]             dlv;
   logic [N_DST-1:0]             grant;

   irq_src_bank #(
      .N_SRC (N_SRC),
      .N_DST (N_DST),
      .PRIO_W(PRIO_W),
      .VEC_W (VEC_W),
      .CFG_W (CFG_W)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (src_raise),
      .cfg_we  (cfg_we),
      .cfg_sel (cfg_sel),
      .cfg_prio(cfg_prio),
      .cfg_vec (cfg_vec),
      .cfg_mask(cfg_mask),
      .cfg_dst (cfg_dst),
      .pend_clr(claimed),
      .isv_set (isv_set),
      .isv_clr (isv_clr),
      .prio    (src_prio),
      .vec     (src_vec),
      .mask    (src_mask),
      .route   (src_route),
      .pend    (src_pend),
      .isv     (src_isv)
   );

   for (genvar d = 0; d < N_DST; d++) begin : g_dst
      logic [N_SRC-1:0] route_col;
      logic [N_SRC-1:0] isv_col;

      for (genvar s = 0; s < N_SRC; s++) begin : g_col
         assign route_col[s] = src_route[s][d];
         assign isv_col[s]   = src_isv[s][d];
      end

      irq_dst_sel #(
         .N_SRC (N_SRC),
         .PRIO_W(PRIO_W)
      ) u_sel (
         .prio   (src_prio),
         .pend   (src_pend),
         .mask   (src_mask),
         .route  (route_col),
         .isv    (isv_col),
         .tp     (tp_q[d]),
         .win_idx(win_idx[d]),
         .dlv    (dlv[d]),
         .eoi_vld(eoi_vld[d]),
         .eoi_idx(eoi_idx[d])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            tp_q[d]    <= '0;
            irq[d]     <= 1'b0;
            ack_vec[d] <= '0;
         end else begin
            if (tp_we && tp_sel == DW'(d))
               tp_q[d] <= PRIO_W'(tp_val % CFG_W'(LEVELS));
            irq[d] <= dlv[d] && !ack[d];
            if (ack[d])
               ack_vec[d] <= grant[d] ? src_vec[win_idx[d]] : spur_vec;
         end
      end
   end

   // Claim chain: a lower-numbered destination takes a shared winner first.
   always_comb begin
      claimed = '0;
      grant   = '0;
      isv_set = '0;
      isv_clr = '0;
      for (int d = 0; d < N_DST; d++) begin
         if (ack[d] && dlv[d] && !claimed[win_idx[d]]) begin
            grant[d]                = 1'b1;
            claimed[win_idx[d]]     = 1'b1;
            isv_set[win_idx[d]][d]  = 1'b1;
         end
         if (eoi[d] && eoi_vld[d])
            isv_clr[eoi_idx[d]][d] = 1'b1;
      end
   end

endmodule

// File: rtl/irq_dlv_chk.sv
module irq_dlv_chk
   import irq_dlv_pkg::*;
#(
   parameter int unsigned N_SRC  = 8,
   parameter int unsigned N_DST  = 2,
   parameter int unsigned VEC_W  = 8
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [N_DST-1:0]                ack,
   input logic [N_DST-1:0]                irq,
   input logic [N_DST-1:0][VEC_W-1:0]     ack_vec,
   input logic [VEC_W-1:0]                spur_vec,
   input logic [N_DST-1:0]                dlv,
   input logic [N_DST-1:0][idx_bits(N_SRC)-1:0] win_idx,
   input logic [N_SRC-1:0]                src_mask,
   input logic [N_SRC-1:0][N_DST-1:0]     isv_set
);

   for (genvar d = 0; d < N_DST; d++) begin : g_d
      p_ack_drops_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
         ack[d] |=> !irq[d]);

      p_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[d] && !dlv[d]) |=> ack_vec[d] == $past(spur_vec));

      p_irq_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
         !ack[d] |=> irq[d] == $past(dlv[d]));

      p_masked_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
         dlv[d] |-> !src_mask[win_idx[d]]);
   end

   for (genvar s = 0; s < N_SRC; s++) begin : g_s
      p_single_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(isv_set[s]));
   end

endmodule

bind irq_dlv_sel irq_dlv_chk #(
   .N_SRC(N_SRC),
   .N_DST(N_DST),
   .VEC_W(VEC_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ack     (ack),
   .irq     (irq),
   .ack_vec (ack_vec),
   .spur_vec(spur_vec),
   .dlv     (dlv),
   .win_idx (win_idx),
   .src_mask(src_mask),
   .isv_set (isv_set)
);

// File: tb/irq_dlv_sel_tb.sv
module irq_dlv_sel_tb;

   localparam int N_SRC  = 8;
   localparam int N_DST  = 2;
   localparam int PRIO_W = 4;
   localparam int VEC_W  = 8;
   localparam int CFG_W  = 8;
   localparam logic [7:0] SPUR = 8'hFF;

   logic                          clk = 1'b0;
   logic                          rst_n;
   logic [N_SRC-1:0]              src_raise;
   logic                          cfg_we;
   logic [2:0]                    cfg_sel;
   logic [CFG_W-1:0]              cfg_prio;
   logic [VEC_W-1:0]              cfg_vec;
   logic                          cfg_mask;
   logic [N_DST-1:0]              cfg_dst;
   logic                          tp_we;
   logic [0:0]                    tp_sel;
   logic [CFG_W-1:0]              tp_val;
   logic [VEC_W-1:0]              spur_vec;
   logic [N_DST-1:0]              ack;
   logic [N_DST-1:0]              eoi;
   logic [N_DST-1:0]              irq;
   logic [N_DST-1:0][VEC_W-1:0]   ack_vec;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_dlv_sel #(
      .N_SRC(N_SRC), .N_DST(N_DST), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .CFG_W(CFG_W)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .src_raise(src_raise),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_prio(cfg_prio), .cfg_vec(cfg_vec),
      .cfg_mask(cfg_mask), .cfg_dst(cfg_dst),
      .tp_we(tp_we), .tp_sel(tp_sel), .tp_val(tp_val), .spur_vec(spur_vec),
      .ack(ack), .eoi(eoi), .irq(irq), .ack_vec(ack_vec)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic reset_dut();
      @(negedge clk);
      rst_n = 1'b0;
      src_raise = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_prio = '0; cfg_vec = '0;
      cfg_mask = 1'b0; cfg_dst = '0; tp_we = 1'b0; tp_sel = '0; tp_val = '0;
      spur_vec = SPUR; ack = '0; eoi = '0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic cfg(input int s, input logic [7:0] p, input logic [7:0] v,
                      input logic m, input logic [1:0] dm);
      cfg_we = 1'b1; cfg_sel = 3'(s); cfg_prio = p; cfg_vec = v; cfg_mask = m; cfg_dst = dm;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_tp(input int d, input logic [7:0] v);
      tp_we = 1'b1; tp_sel = 1'(d); tp_val = v;
      @(negedge clk);
      tp_we = 1'b0;
   endtask

   task automatic raise(input logic [N_SRC-1:0] bits);
      src_raise = bits;
      @(negedge clk);
      src_raise = '0;
      idle(1);
   endtask

   task automatic do_ack(input logic [1:0] bits);
      ack = bits;
      @(negedge clk);
      ack = '0;
   endtask

   task automatic do_eoi(input logic [1:0] bits);
      eoi = bits;
      @(negedge clk);
      eoi = '0;
      idle(1);
   endtask

   task automatic t_reset();
      reset_dut();
      chk("R3", "irq after reset", int'(irq), 0);
      chk("R8", "ack_vec0 after reset", int'(ack_vec[0]), 0);
   endtask

   task automatic t_route_ack();
      reset_dut();
      cfg(3, 8'd5, 8'h33, 1'b0, 2'b01);
      raise(8'b0000_1000);
      chk("R1", "irq routed to d0 only", int'(irq), 1);
      do_ack(2'b01);
      chk("R8", "ack vector", int'(ack_vec[0]), 'h33);
      chk("R8", "irq low in ack cycle", int'(irq[0]), 0);
      idle(1);
      chk("R8", "irq stays low, source in service", int'(irq[0]), 0);
      do_ack(2'b01);
      chk("R9", "spurious vector", int'(ack_vec[0]), SPUR);
      raise(8'b0000_1000);
      chk("R3", "equal priority in service blocks", int'(irq[0]), 0);
      do_eoi(2'b01);
      chk("R10", "re-raised source delivered after eoi", int'(irq[0]), 1);
   endtask

   task automatic t_priority();
      reset_dut();
      cfg(1, 8'd7, 8'h11, 1'b0, 2'b01);
      cfg(2, 8'd7, 8'h22, 1'b0, 2'b01);
      cfg(4, 8'd9, 8'h44, 1'b0, 2'b01);
      raise(8'b0001_0110);
      do_ack(2'b01);
      chk("R2", "highest priority wins", int'(ack_vec[0]), 'h44);
      idle(1);
      chk("R3", "lower priority blocked by in service", int'(irq[0]), 0);
      do_eoi(2'b01);
      chk("R10", "delivery resumes after eoi", int'(irq[0]), 1);
      do_ack(2'b01);
      chk("R2", "tie goes to lowest index", int'(ack_vec[0]), 'h11);
      idle(1);
      chk("R3", "equal priority blocked", int'(irq[0]), 0);
      do_eoi(2'b01);
      do_ack(2'b01);
      chk("R2", "remaining tie source", int'(ack_vec[0]), 'h22);
   endtask

   task automatic t_task_prio();
      reset_dut();
      cfg(5, 8'h3A, 8'h55, 1'b0, 2'b01);
      set_tp(0, 8'h1A);
      raise(8'b0010_0000);
      chk("R4", "task prio 0x1A mod 16 = 10 blocks priority 10", int'(irq[0]), 0);
      set_tp(0, 8'h29);
      idle(1);
      chk("R5", "priority 0x3A mod 16 = 10 beats task prio 9", int'(irq[0]), 1);
      do_ack(2'b01);
      chk("R4", "vector after threshold lowered", int'(ack_vec[0]), 'h55);
   endtask

   task automatic t_mask_zero();
      reset_dut();
      cfg(6, 8'd9, 8'h66, 1'b1, 2'b01);
      raise(8'b0100_0000);
      chk("R6", "masked source not delivered", int'(irq[0]), 0);
      do_ack(2'b01);
      chk("R6", "ack on masked source gives spurious", int'(ack_vec[0]), SPUR);
      cfg(6, 8'd9, 8'h66, 1'b0, 2'b01);
      idle(1);
      chk("R6", "unmasked pending source delivered", int'(irq[0]), 1);
      do_ack(2'b01);
      chk("R9", "spurious ack left pending intact", int'(ack_vec[0]), 'h66);
      reset_dut();
      cfg(7, 8'd0, 8'h77, 1'b0, 2'b11);
      raise(8'b1000_0000);
      chk("R7", "priority 0 never delivers", int'(irq), 0);
      do_ack(2'b11);
      chk("R7", "priority 0 ack d1 spurious", int'(ack_vec[1]), SPUR);
   endtask

   task automatic t_collide();
      reset_dut();
      cfg(2, 8'd4, 8'h2C, 1'b0, 2'b11);
      raise(8'b0000_0100);
      chk("R1", "shared source raises both lines", int'(irq), 3);
      do_ack(2'b11);
      chk("R11", "d0 takes shared winner", int'(ack_vec[0]), 'h2C);
      chk("R11", "d1 gets spurious", int'(ack_vec[1]), SPUR);
      idle(1);
      chk("R11", "source claimed once, both lines low", int'(irq), 0);
   endtask

   task automatic t_nested_eoi();
      reset_dut();
      cfg(0, 8'd3, 8'hA0, 1'b0, 2'b01);
      raise(8'b0000_0001);
      do_ack(2'b01);
      chk("R8", "first nested vector", int'(ack_vec[0]), 'hA0);
      cfg(1, 8'd8, 8'hA1, 1'b0, 2'b01);
      raise(8'b0000_0010);
      chk("R3", "higher priority preempts in service", int'(irq[0]), 1);
      do_ack(2'b01);
      chk("R8", "second nested vector", int'(ack_vec[0]), 'hA1);
      cfg(2, 8'd5, 8'hA2, 1'b0, 2'b01);
      raise(8'b0000_0100);
      chk("R3", "priority 5 blocked by 8 in service", int'(irq[0]), 0);
      do_eoi(2'b10);
      chk("R10", "eoi on idle d1 has no effect on d0", int'(irq[0]), 0);
      do_eoi(2'b01);
      chk("R10", "eoi retired priority 8, 5 beats 3", int'(irq[0]), 1);
      do_ack(2'b01);
      chk("R10", "vector after nested eoi", int'(ack_vec[0]), 'hA2);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      t_reset();
      t_route_ack();
      t_priority();
      t_task_prio();
      t_mask_zero();
      t_collide();
      t_nested_eoi();
      idle(2);
      finish_run();
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule